// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block sits on the device side of a flash model and decides what word a read returns while an internal program or erase is running. When an operation starts, it captures the operation kind and bit 7 of the word being programmed. During the busy phase, a read gets a status word instead of array contents. Bit 7 is the polling bit and depends on the operation kind. Bit 6 alternates on each read. Every other bit carries a fixed placeholder pattern, so that a host which trusts them too early is easy to spot. The array contents and the cell programming are outside this block: stored data arrives on an input.

The sequencer has three states: `ST_IDLE`, `ST_BUSY` and `ST_SETTLE`. Transition START (`ST_IDLE` to `ST_BUSY`) happens when an operation-start pulse arrives in `ST_IDLE`. It loads the busy counter. Transition DONE (`ST_BUSY` to `ST_SETTLE`) happens when the busy counter reaches zero. It loads the settle counter, which covers the settling time of about 1 µs at the clock frequency given as a parameter. Transition SETTLED (`ST_SETTLE` to `ST_IDLE`) happens when the settle counter reaches zero. During settling, bit 7 already shows true array data, bit 6 holds its last value, and the other bits still carry the placeholder.

Top module: `flash_busy_responder`

## Requirements
- R1: After reset, `rd_data` is 0 and the block is in `ST_IDLE`.
- R2: In `ST_IDLE`, a read strobe sampled at a clock edge loads `array_word` unchanged into `rd_data` at that edge.
- R3: In `ST_BUSY` during a program (`op_is_erase`=0 at start), bit 7 of a read returns the inverse of `prog_word[7]` as captured at start.
- R4: In `ST_BUSY` during an erase (`op_is_erase`=1 at start), bit 7 of a read returns 0.
- R5: Bit 6 is cleared at START. Each read in `ST_BUSY` returns the current bit 6 and then inverts it. Clock cycles without a read leave it unchanged.
- R6: During `ST_BUSY` and `ST_SETTLE`, all bits other than 7 and 6 return the placeholder `FILL_WORD` (default 16'h5A3C).
- R7: `ST_BUSY` lasts exactly `BUSY_CYCLES` clock edges (default 40) after the START edge. `ST_SETTLE` then lasts `SETTLE_CYCLES` edges, which is 125 at 125 MHz and 1000 ns. During settling, bit 7 equals `array_word[7]` and bit 6 holds its last busy value.
- R8: After SETTLED, reads return `array_word` in full again.
- R9: An operation-start pulse outside `ST_IDLE` is ignored: the captured kind, the captured word and the timing stay as they were.
- R10: `rd_data` keeps its value on every edge without a read strobe.
- R11: Changes on `prog_word` or `op_is_erase` after START do not affect the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse that starts an internal operation |
| op_is_erase | input | 1 | Operation kind at start: 1 erase, 0 program |
| prog_word | input | 16 | Word being programmed; bit 7 is captured at start |
| array_word | input | 16 | Stored array data at the read address |
| rd_stb | input | 1 | Read access, one per cycle held high |
| rd_data | output | 16 | Word returned by the last read |

## Verification
Every read is registered, so the word for a strobe sampled at edge e is due at `rd_data` just after edge e. The monitor compares it at the falling edge that follows. The driver computes each expected word before it raises the strobe. It uses its own count of edges since START: the phase is busy for counts 0 to `BUSY_CYCLES`-1, settling up to `BUSY_CYCLES`+`SETTLE_CYCLES`-1, and idle after that. This lets reads placed on the last busy edge and the first settle edge test the DONE boundary exactly.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_SETTLE = 2'd2
    } fbr_state_e;
endpackage

// File: rtl/fbr_sequencer.sv
module fbr_sequencer
    import fbr_pkg::*;
#(
    parameter int BUSY_CYCLES   = 40,
    parameter int SETTLE_CYCLES = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic       op_is_erase,
    input  logic       prog_b7,
    output fbr_state_e state,
    output logic       launch,
    output logic       erase_q,
    output logic       prog_b7_q
);
    localparam int MAX_CNT = (BUSY_CYCLES > SETTLE_CYCLES) ? BUSY_CYCLES : SETTLE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] BUSY_LOAD   = CNT_W'(BUSY_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);

    fbr_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign launch   = (state == ST_IDLE) && op_start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state: START, DONE, SETTLED
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (op_start) state_nx = ST_BUSY;
            ST_BUSY:   if (cnt_zero) state_nx = ST_SETTLE;
            ST_SETTLE: if (cnt_zero) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // phase counter and captured operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            erase_q   <= 1'b0;
            prog_b7_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (op_start) begin
                        cnt       <= BUSY_LOAD;
                        erase_q   <= op_is_erase;
                        prog_b7_q <= prog_b7;
                    end
                end
                ST_BUSY: begin
                    if (cnt_zero) cnt <= SETTLE_LOAD;
                    else          cnt <= cnt - 1'b1;
                end
                ST_SETTLE: begin
                    if (!cnt_zero) cnt <= cnt - 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assert_busy_not_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |=> (state != ST_IDLE));
    assert_settle_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> ($past(state) != ST_IDLE));
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && op_start) |=> ($stable(erase_q) && $stable(prog_b7_q)));
endmodule

// File: rtl/fbr_toggle.sv
module fbr_toggle
    import fbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fbr_state_e state,
    input  logic       launch,
    input  logic       rd_stb,
    output logic       tog
);
    logic flip;
    assign flip = rd_stb && (state == ST_BUSY);

    always_ff @(posedge clk) begin
        if (!rst_n)      tog <= 1'b0;
        else if (launch) tog <= 1'b0;
        else if (flip)   tog <= ~tog;
    end

    assert_toggle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flip && !launch) |=> $stable(tog));
    assert_toggle_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (tog != $past(tog)));
endmodule

// File: rtl/fbr_read_mux.sv
module fbr_read_mux
    import fbr_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] FILL_WORD = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fbr_state_e        state,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] array_word,
    input  logic              erase_q,
    input  logic              prog_b7_q,
    input  logic              tog,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

    logic              poll_val;
    logic              busy_or_settle;
    logic [DATA_W-1:0] resp;

    assign busy_or_settle = (state != ST_IDLE);

    always_comb begin
        unique case (state)
            ST_BUSY:   poll_val = erase_q ? 1'b0 : ~prog_b7_q;
            ST_SETTLE: poll_val = array_word[POLL_BIT];
            default:   poll_val = array_word[POLL_BIT];
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign resp[i] = poll_val;
        end else if (i == TOG_BIT) begin : g_tog
            assign resp[i] = busy_or_settle ? tog : array_word[i];
        end else begin : g_fill
            assign resp[i] = busy_or_settle ? FILL_WORD[i] : array_word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= resp;
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd_stb) |=> (rd_data == $past(array_word)));
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && erase_q && rd_stb) |=> (rd_data[POLL_BIT] == 1'b0));
    assert_settle_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && rd_stb) |=> (rd_data[POLL_BIT] == $past(array_word[POLL_BIT])));
endmodule

// File: rtl/flash_busy_responder.sv
module flash_busy_responder
    import fbr_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                BUSY_CYCLES = 40,
    parameter int                CLK_MHZ   = 125,
    parameter int                SETTLE_NS = 1000,
    parameter logic [DATA_W-1:0] FILL_WORD = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic [DATA_W-1:0] prog_word,
    input  logic [DATA_W-1:0] array_word,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SETTLE_RAW    = (CLK_MHZ * SETTLE_NS + 999) / 1000;
    localparam int SETTLE_CYCLES = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

    fbr_state_e state;
    logic       launch;
    logic       erase_q;
    logic       prog_b7_q;
    logic       tog;

    fbr_sequencer #(
        .BUSY_CYCLES  (BUSY_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_is_erase(op_is_erase),
        .prog_b7    (prog_word[7]),
        .state      (state),
        .launch     (launch),
        .erase_q    (erase_q),
        .prog_b7_q  (prog_b7_q)
    );

    fbr_toggle u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .launch(launch),
        .rd_stb(rd_stb),
        .tog   (tog)
    );

    fbr_read_mux #(
        .DATA_W   (DATA_W),
        .FILL_WORD(FILL_WORD)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .rd_stb    (rd_stb),
        .array_word(array_word),
        .erase_q   (erase_q),
        .prog_b7_q (prog_b7_q),
        .tog       (tog),
        .rd_data   (rd_data)
    );
endmodule

// File: tb/tb_flash_busy_responder.sv
`timescale 1ns/1ps
module tb_flash_busy_responder;
    localparam int BUSY = 40;
    localparam int SETL = 125;
    localparam logic [15:0] FILL = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic        op_is_erase = 1'b0;
    logic [15:0] prog_word = '0;
    logic [15:0] array_word = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_data;

    flash_busy_responder dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .prog_word(prog_word), .array_word(array_word), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [15:0] exp; string tag; } item_t;
    item_t q[$];

    // bench model of the phase
    int   since = -1;
    logic m_erase = 0, m_b7 = 0, m_tog = 0;

    always @(posedge clk) begin
        if (!rst_n) since = -1;
        else if (since < 0) begin
            if (op_start) begin
                since = 0; m_erase = op_is_erase; m_b7 = prog_word[7]; m_tog = 0;
            end
        end else begin
            since = since + 1;
            if (since == BUSY + SETL) since = -1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    logic seen = 0;
    always @(posedge clk) seen <= rd_stb;
    always @(negedge clk) begin
        if (seen && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(rd_data === it.exp, it.tag, rd_data, it.exp);
        end
    end

    // driver: called just after a falling edge
    task automatic rd(input logic [15:0] arr, input string tag);
        logic [15:0] e;
        array_word = arr;
        if (since < 0) e = arr;
        else begin
            e = FILL & ~16'h00C0;
            if (since < BUSY) begin
                e[7] = m_erase ? 1'b0 : ~m_b7;
                e[6] = m_tog;
                m_tog = ~m_tog;
            end else begin
                e[7] = arr[7];
                e[6] = m_tog;
            end
        end
        q.push_back('{e, tag});
        rd_stb = 1'b1;
        @(negedge clk); #1;
        rd_stb = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic start(input logic er, input logic [15:0] w);
        op_is_erase = er; prog_word = w; op_start = 1'b1;
        @(negedge clk); #1;
        op_start = 1'b0;
    endtask

    task automatic wait_since(input int t);
        while (since != t) begin @(negedge clk); #1; end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1200000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] held;
        step(3); rst_n = 1'b1; step(1);
        check(rd_data === 16'h0, "R1 reset value", rd_data, 16'h0);
        // idle reads
        rd(16'hBEEF, "R2 idle read a");
        rd(16'h0041, "R2 idle read b");
        rd(16'hFF80, "R2 idle read c");
        step(2);
        held = rd_data;
        array_word = 16'h1111; step(4);
        check(rd_data === held, "R10 hold without strobe", rd_data, held);
        // program with bit7 = 0
        start(1'b0, 16'h1234);
        rd(16'hFFFF, "R3 R6 program poll 1");
        rd(16'hFFFF, "R5 toggle 2");
        step(5);
        rd(16'h0000, "R5 toggle after idle gap");
        held = rd_data; step(3);
        check(rd_data === held, "R10 hold during busy", rd_data, held);
        prog_word = 16'h00FF; op_is_erase = 1'b1;
        rd(16'h0000, "R11 latched kind");
        start(1'b1, 16'h0080);
        rd(16'h7777, "R9 restart ignored");
        wait_since(BUSY - 1);
        rd(16'hFF7F, "R7 last busy edge");
        rd(16'h0080, "R7 first settle edge b7 true");
        rd(16'h0000, "R7 R6 settle fill");
        wait_since(BUSY + SETL - 1);
        rd(16'h00FF, "R7 last settle edge");
        rd(16'hCAFE, "R8 idle after settle");
        // program with bit7 = 1
        step(2);
        start(1'b0, 16'h0080);
        rd(16'h1234, "R3 program poll inverse 0");
        rd(16'h1234, "R5 toggle second");
        rd(16'h1234, "R5 toggle third");
        wait_since(BUSY + 3);
        rd(16'h00C0, "R7 toggle held in settle");
        wait_since(-1);
        rd(16'hA55A, "R8 idle read");
        // erase
        start(1'b1, 16'h0000);
        rd(16'hFFFF, "R4 erase poll 0");
        step(7);
        rd(16'hFFFF, "R4 R5 erase toggle");
        wait_since(BUSY);
        rd(16'hFFFF, "R7 erase settle b7 one");
        wait_since(-1);
        rd(16'hFFFF, "R8 erased word");
        step(3);
        if (q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard left %0d items expected 0", q.size());
        end
        summary();
    end
endmodule